// File: doc/BRIEF.md
# Pipeline Flow Property Monitor

This block is a passive run-time checker for the control logic of an in-order pipeline. Each cycle it watches the action the program counter takes (advance sequentially, take a branch, or hold) and the action every instruction latch takes (accept from upstream, hold, or load a bubble). It also watches a valid bit per latch. It raises sticky error flags when the control breaks one of three rules. The first rule is that exactly one action is chosen per state register. The second is that a latch never flows while an upstream neighbour holds, which would duplicate an instruction. The third is that a valid instruction does not hold forever once everything after it has drained.

Latches are numbered in pipeline order, with a higher index meaning later in the pipe. Parent/child links come from a parameter bit matrix. The monitor drives nothing back into the pipeline. It sits beside the control logic and reports the flags and the index of the first latch that failed.

Top module: `pfm_monitor`

## Requirements
- R1: When the three PC action inputs (pc_seq, pc_branch, pc_stall) do not have exactly one bit set, err_pc is set after that clock edge.
- R2: When any latch i does not have exactly one of ir_flow[i], ir_stall[i], ir_nop[i] set, err_det is set after that edge.
- R3: Bit p*NUM_LATCH+c of ADJ marks latch p as a parent of latch c. If latch c flows while any of its parents stalls, err_order is set. A latch that stalls or loads a bubble while its parents stall raises nothing.
- R4: A latch can be valid and stalled while every latch with a higher index is invalid. When that happens for STALL_LIMIT consecutive cycles, err_bound is set after the STALL_LIMIT-th such cycle, and not after STALL_LIMIT-1 of them. Any cycle that breaks the run restarts the count.
- R5: A stalled valid latch whose later latches hold at least one valid instruction never raises err_bound, however long it waits.
- R6: The flags stay set until clr is high at a clock edge. That edge clears all flags and first_idx to 0, even when a violation is present in the same cycle.
- R7: first_idx takes the lowest index among latches failing R2, R3 or R4 in the first cycle with any latch error after reset or clear. It then holds until clear. A PC-only error does not capture it.
- R8: While reset is low, and at the first clock edge after reset is released, no violation is recorded. All flags and first_idx read 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags and capture |
| pc_seq | input | 1 | PC advances sequentially |
| pc_branch | input | 1 | PC loads a branch target |
| pc_stall | input | 1 | PC holds |
| ir_flow | input | NUM_LATCH | Latch accepts from its parent |
| ir_stall | input | NUM_LATCH | Latch holds its contents |
| ir_nop | input | NUM_LATCH | Latch loads a bubble |
| ir_valid | input | NUM_LATCH | Latch holds a real instruction |
| err_pc | output | 1 | Sticky PC action error |
| err_det | output | 1 | Sticky latch action error |
| err_order | output | 1 | Sticky in-order flow error |
| err_bound | output | 1 | Sticky bounded-progress error |
| first_idx | output | max(1,clog2(NUM_LATCH)) | Lowest failing latch of the first latch error |

## Verification
The bench runs on a four-latch fork/join graph and applies several action patterns. These are clean flow everywhere, PC codes with zero and two bits, a latch with no action, a latch with two actions, a stalled parent under a flowing child, a fully stalled fork under a bubbling join, and a join with only one stalled parent. Together they separate "any parent" from "all parents" and show that a stall or bubble below a stalled parent is accepted. A mixed pattern with both latch and PC faults shows the lowest-index capture. Stall runs of exactly STALL_LIMIT-1 and STALL_LIMIT cycles, a run broken by one flow cycle, and a long stall behind a busy later latch separate the bound count from the downstream-idle condition.

// File: rtl/pfm_pkg.sv
// Shared types and helpers for the pipeline flow property monitor.
package pfm_pkg;

    // Sticky error flags held by the monitor.
    typedef struct packed {
        logic pc;
        logic det;
        logic order;
        logic bound;
    } pfm_err_t;

    // True when exactly one of three action bits is set.
    function automatic logic one_of3(input logic a, input logic b, input logic c);
        return (a ^ b ^ c) & ~(a & b & c);
    endfunction

endpackage

// File: rtl/pfm_det_chk.sv
// Determinism check: the PC and every latch must choose exactly one action.
// Assumes: pure combinational, result is gated by the caller.
module pfm_det_chk #(
    parameter int N = 4
) (
    input  logic         pc_seq,
    input  logic         pc_branch,
    input  logic         pc_stall,
    input  logic [N-1:0] ir_flow,
    input  logic [N-1:0] ir_stall,
    input  logic [N-1:0] ir_nop,
    output logic         pc_bad,
    output logic [N-1:0] ir_bad
);

    // PC action code must be one-hot.
    assign pc_bad = ~pfm_pkg::one_of3(pc_seq, pc_branch, pc_stall);

    // Per-latch action code must be one-hot.
    for (genvar i = 0; i < N; i++) begin : g_lat
        assign ir_bad[i] = ~pfm_pkg::one_of3(ir_flow[i], ir_stall[i], ir_nop[i]);
    end

endmodule

// File: rtl/pfm_order_chk.sv
// In-order check: a latch may not flow while any of its parents stalls.
// Assumes: ADJ bit p*N+c set means latch p feeds latch c.
module pfm_order_chk #(
    parameter int                 N   = 4,
    parameter logic [N*N-1:0]     ADJ = '0
) (
    input  logic [N-1:0] ir_flow,
    input  logic [N-1:0] ir_stall,
    output logic [N-1:0] ord_bad
);

    for (genvar c = 0; c < N; c++) begin : g_child
        logic [N-1:0] par_mask;
        // Gather the parent column of this child from the matrix.
        for (genvar p = 0; p < N; p++) begin : g_par
            assign par_mask[p] = ADJ[p*N+c];
        end
        // Flow below any stalled parent duplicates an instruction.
        assign ord_bad[c] = ir_flow[c] & (|(par_mask & ir_stall));
    end

endmodule

// File: rtl/pfm_bound_chk.sv
// Bounded-progress check: counts consecutive cycles a valid latch stalls
// while every later (higher-index) latch is empty.
// Assumes: LIMIT >= 2; counting only while armed and not clearing.
module pfm_bound_chk #(
    parameter int N     = 4,
    parameter int LIMIT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed,
    input  logic         clr,
    input  logic [N-1:0] ir_valid,
    input  logic [N-1:0] ir_stall,
    output logic [N-1:0] bnd_bad
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    for (genvar i = 0; i < N; i++) begin : g_lat
        logic          down_idle;
        logic          qual;
        logic [CW-1:0] cnt;

        // Later stages are idle when no higher-index latch is valid.
        if (i == N - 1) begin : g_tail
            assign down_idle = 1'b1;
        end else begin : g_mid
            assign down_idle = ~(|ir_valid[N-1:i+1]);
        end

        assign qual = ir_valid[i] & ir_stall[i] & down_idle;

        // Consecutive qualifying stall counter, saturating at LIMIT-1.
        always_ff @(posedge clk) begin
            if (!rst_n || !armed || clr || !qual) begin
                cnt <= '0;
            end else if (cnt != LAST) begin
                cnt <= cnt + 1'b1;
            end
        end

        assign bnd_bad[i] = armed & qual & (cnt == LAST);
    end

endmodule

// File: rtl/pfm_monitor.sv
// Pipeline flow property monitor: passive checker of PC and latch control.
// Holds sticky flags for determinism, in-order flow and bounded progress,
// and captures the lowest failing latch of the first latch error.
// Assumes: latches are indexed in pipeline order; checks start on the
// second clock edge after reset release.
module pfm_monitor #(
    parameter int                           NUM_LATCH   = 4,
    parameter int                           STALL_LIMIT = 16,
    parameter logic [NUM_LATCH*NUM_LATCH-1:0] ADJ       = 16'h0842,
    localparam int                          IW          = (NUM_LATCH > 1) ? $clog2(NUM_LATCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 pc_seq,
    input  logic                 pc_branch,
    input  logic                 pc_stall,
    input  logic [NUM_LATCH-1:0] ir_flow,
    input  logic [NUM_LATCH-1:0] ir_stall,
    input  logic [NUM_LATCH-1:0] ir_nop,
    input  logic [NUM_LATCH-1:0] ir_valid,
    output logic                 err_pc,
    output logic                 err_det,
    output logic                 err_order,
    output logic                 err_bound,
    output logic [IW-1:0]        first_idx
);

    logic                 armed;
    logic                 captured;
    logic                 pc_bad;
    logic [NUM_LATCH-1:0] ir_bad;
    logic [NUM_LATCH-1:0] ord_bad;
    logic [NUM_LATCH-1:0] bnd_bad;
    logic [NUM_LATCH-1:0] lat_bad;
    logic [IW-1:0]        low_idx;
    pfm_pkg::pfm_err_t    flg_q;

    pfm_det_chk #(.N(NUM_LATCH)) u_det (
        .pc_seq    (pc_seq),
        .pc_branch (pc_branch),
        .pc_stall  (pc_stall),
        .ir_flow   (ir_flow),
        .ir_stall  (ir_stall),
        .ir_nop    (ir_nop),
        .pc_bad    (pc_bad),
        .ir_bad    (ir_bad)
    );

    pfm_order_chk #(.N(NUM_LATCH), .ADJ(ADJ)) u_ord (
        .ir_flow  (ir_flow),
        .ir_stall (ir_stall),
        .ord_bad  (ord_bad)
    );

    pfm_bound_chk #(.N(NUM_LATCH), .LIMIT(STALL_LIMIT)) u_bnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .clr      (clr),
        .ir_valid (ir_valid),
        .ir_stall (ir_stall),
        .bnd_bad  (bnd_bad)
    );

    // Arm checking one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign lat_bad = ir_bad | ord_bad | bnd_bad;

    // Lowest-index failing latch this cycle.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_LATCH - 1; i >= 0; i--) begin
            if (lat_bad[i]) low_idx = IW'(i);
        end
    end

    // Sticky flags, cleared by reset or clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flg_q <= '0;
        end else if (armed) begin
            flg_q.pc    <= flg_q.pc    | pc_bad;
            flg_q.det   <= flg_q.det   | (|ir_bad);
            flg_q.order <= flg_q.order | (|ord_bad);
            flg_q.bound <= flg_q.bound | (|bnd_bad);
        end
    end

    // Capture the first failing latch index once per clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            captured  <= 1'b0;
            first_idx <= '0;
        end else if (armed && !captured && (|lat_bad)) begin
            captured  <= 1'b1;
            first_idx <= low_idx;
        end
    end

    assign err_pc    = flg_q.pc;
    assign err_det   = flg_q.det;
    assign err_order = flg_q.order;
    assign err_bound = flg_q.bound;

endmodule

// File: rtl/pfm_monitor_sva.sv
// Property checker for pfm_monitor, attached by bind.
// Assumes: sees the top's ports plus its arm and capture state.
module pfm_monitor_sva #(
    parameter int NUM_LATCH = 4,
    parameter int IW        = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic                 pc_seq,
    input logic                 pc_branch,
    input logic                 pc_stall,
    input logic [NUM_LATCH-1:0] ir_flow,
    input logic [NUM_LATCH-1:0] ir_stall,
    input logic [NUM_LATCH-1:0] ir_nop,
    input logic                 err_pc,
    input logic                 err_det,
    input logic                 err_order,
    input logic                 err_bound,
    input logic [IW-1:0]        first_idx,
    input logic                 armed,
    input logic                 captured
);

    logic [3:0] flags;
    assign flags = {err_pc, err_det, err_order, err_bound};

    assert_pc_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !clr && ($countones({pc_seq, pc_branch, pc_stall}) != 1) |=> err_pc);

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_det
        assert_ir_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            armed && !clr && ($countones({ir_flow[i], ir_stall[i], ir_nop[i]}) != 1) |=> err_det);
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == 4'b0000) && (first_idx == '0));

    assert_first_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        captured && !clr |=> $stable(first_idx));

    assert_quiet_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (flags == 4'b0000));

endmodule

bind pfm_monitor pfm_monitor_sva #(.NUM_LATCH(NUM_LATCH), .IW(IW)) u_sva (.*);

// File: tb/sim_pfm_monitor.sv
`timescale 1ns/1ps
module sim_pfm_monitor;

    localparam int N   = 4;
    localparam int LIM = 16;
    // Fork/join: 0->1, 0->2, 1->3, 2->3.
    localparam logic [N*N-1:0] ADJ_T = 16'h0886;

    logic clk = 1'b0;
    logic rst_n, clr;
    logic pc_seq, pc_branch, pc_stall;
    logic [N-1:0] ir_flow, ir_stall, ir_nop, ir_valid;
    logic err_pc, err_det, err_order, err_bound;
    logic [1:0] first_idx;
    logic [3:0] flg;
    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfm_monitor #(.NUM_LATCH(N), .STALL_LIMIT(LIM), .ADJ(ADJ_T)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .pc_seq(pc_seq), .pc_branch(pc_branch), .pc_stall(pc_stall),
        .ir_flow(ir_flow), .ir_stall(ir_stall), .ir_nop(ir_nop), .ir_valid(ir_valid),
        .err_pc(err_pc), .err_det(err_det), .err_order(err_order), .err_bound(err_bound),
        .first_idx(first_idx)
    );

    assign flg = {err_pc, err_det, err_order, err_bound};

    // Fields: pc{stall,branch,seq}, flow, stall, nop, valid, exp{pc,det,order,bound}, idx
    localparam logic [24:0] VEC [0:9] = '{
        {3'b001, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0},
        {3'b000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 2'd0},
        {3'b011, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 2'd0},
        {3'b001, 4'b1011, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 2'd2},
        {3'b001, 4'b1111, 4'b0000, 4'b0010, 4'b0000, 4'b0100, 2'd1},
        {3'b001, 4'b1010, 4'b0001, 4'b0100, 4'b0000, 4'b0010, 2'd1},
        {3'b001, 4'b0000, 4'b0111, 4'b1000, 4'b0000, 4'b0000, 2'd0},
        {3'b001, 4'b1101, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 2'd3},
        {3'b111, 4'b0010, 4'b0101, 4'b0000, 4'b0000, 4'b1110, 2'd1},
        {3'b001, 4'b0111, 4'b1000, 4'b0000, 4'b1000, 4'b0000, 2'd0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [2:0] pc, input logic [3:0] fl, input logic [3:0] st,
                         input logic [3:0] np, input logic [3:0] vd);
        {pc_stall, pc_branch, pc_seq} = pc;
        ir_flow = fl; ir_stall = st; ir_nop = np; ir_valid = vd;
    endtask

    task automatic idle();
        drive(3'b001, 4'b1111, 4'b0000, 4'b0000, 4'b0000);
    endtask

    task automatic do_clear();
        idle(); clr = 1'b1; step(); clr = 1'b0;
    endtask

    task automatic chk_flags(input string rq, input logic [3:0] exp);
        total++;
        if (flg !== exp) begin
            fails++;
            $display("FAIL %s: flags got %b expected %b", rq, flg, exp);
        end
    endtask

    task automatic chk_idx(input string rq, input logic [1:0] exp);
        total++;
        if (first_idx !== exp) begin
            fails++;
            $display("FAIL %s: first_idx got %0d expected %0d", rq, first_idx, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0; clr = 1'b0;
        drive(3'b000, 4'b1111, 4'b0000, 4'b0000, 4'b0000);
        step(); step();
        chk_flags("R8 reset flags", 4'b0000);
        chk_idx("R8 reset idx", 2'd0);
        rst_n = 1'b1;
        step();
        chk_flags("R8 first edge suppressed", 4'b0000);
        step();
        chk_flags("R1 pc none after arming", 4'b1000);
        clr = 1'b1; step(); clr = 1'b0;
        chk_flags("R6 clear dominates violation", 4'b0000);
        step();
        chk_flags("R1 pc error returns", 4'b1000);
        idle(); step(); step(); step();
        chk_flags("R6 sticky after legal cycles", 4'b1000);

        // Vector table.
        for (int k = 0; k < 10; k++) begin
            do_clear();
            drive(VEC[k][24:22], VEC[k][21:18], VEC[k][17:14], VEC[k][13:10], VEC[k][9:6]);
            step();
            chk_flags($sformatf("R1/R2/R3 vector %0d", k), VEC[k][5:2]);
            chk_idx($sformatf("R7 vector %0d", k), VEC[k][1:0]);
        end

        // First index holds through later errors.
        do_clear();
        drive(3'b001, 4'b1011, 4'b0000, 4'b0000, 4'b0000); step();
        chk_idx("R7 first capture latch 2", 2'd2);
        drive(3'b001, 4'b1110, 4'b0000, 4'b0000, 4'b0000); step();
        chk_idx("R7 hold against later latch 0", 2'd2);
        do_clear();
        drive(3'b000, 4'b1111, 4'b0000, 4'b0000, 4'b0000); step();
        chk_idx("R7 pc error does not capture", 2'd0);
        drive(3'b001, 4'b0111, 4'b0000, 4'b0000, 4'b0000); step();
        chk_idx("R7 later latch 3 captured", 2'd3);

        // Bound: exactly LIM-1 then LIM stall cycles.
        do_clear();
        drive(3'b001, 4'b0111, 4'b1000, 4'b0000, 4'b1000);
        repeat (LIM - 1) step();
        chk_flags("R4 no error at limit-1", 4'b0000);
        step();
        chk_flags("R4 error at limit", 4'b0001);
        chk_idx("R4 bound index", 2'd3);

        // Bound: run broken by one flow cycle restarts.
        do_clear();
        drive(3'b001, 4'b0111, 4'b1000, 4'b0000, 4'b1000);
        repeat (10) step();
        drive(3'b001, 4'b1111, 4'b0000, 4'b0000, 4'b1000); step();
        drive(3'b001, 4'b0111, 4'b1000, 4'b0000, 4'b1000);
        repeat (LIM - 1) step();
        chk_flags("R4 restarted count below limit", 4'b0000);
        step();
        chk_flags("R4 restarted count reaches limit", 4'b0001);

        // Busy later latch keeps a long stall legal.
        do_clear();
        drive(3'b001, 4'b0101, 4'b0010, 4'b1000, 4'b0110);
        repeat (40) step();
        chk_flags("R5 stall behind busy latch", 4'b0000);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule